// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block is a 64-entry, fully associative address translation cache. The operating system maintains its contents entirely on its own. Software loads three staging registers through a small register port: an index, an entry-high word and an entry-low word. It then issues one of four commands:

- **Indexed read** copies an entry into the staging registers.
- **Indexed write** copies the staging registers into the entry at the index.
- **Random write** does the same at a position chosen by a free-running counter.
- **Probe** searches for an entry whose high word equals the staged one.

Alongside the command side, a combinational lookup port translates a virtual address. It uses the current address-space ID and an access type that marks a store. The port returns the physical address, a non-cacheable flag and a fault cause code. Write permission is carried by the dirty bit, so no separate read-only flag exists. Trap handling and page table walking live outside the block; it only reports the cause.

Top module: `soft_tlb`

## Requirements
- R1: Reset is synchronous and active high. It clears the index, staging-high and staging-low registers to 0, sets the random index to 63, and clears every entry, so that any lookup with a nonzero page number reports a miss.
- R2: A register write with `stg_we_i` high loads `stg_wdata_i` into the register chosen by `stg_sel_i`: 0 selects the index, 1 the low word, 2 the high word, and 3 selects nothing. The value is visible on `index_o`, `lo_o` or `hi_o` after the next rising edge.
- R3: `cmd_i`=2 (indexed write) stores {high, low} into the entry numbered by `index_o[5:0]`. `cmd_i`=1 (indexed read) loads that entry's high and low words into the staging registers on the next edge.
- R4: The random index `rand_o` decrements by one each clock. From 8 it goes to 63, so it never leaves the range 8..63.
- R5: `cmd_i`=3 (random write) stores {high, low} into the entry numbered by the value of `rand_o` at the clock edge that takes the command.
- R6: `cmd_i`=4 (probe) writes to the index register the lowest entry number whose full 32-bit high word equals the staged high word. When no entry matches, it writes 32'h8000_0000.
- R7: The high word holds the page number in bits 31..12 and the address-space ID in bits 11..0. The low word holds the physical page in bits 31..12, Global in bit 3, Dirty in bit 2, NonCacheable in bit 1 and Valid in bit 0. An entry matches a lookup when the page numbers are equal and either Global is set or the IDs are equal. On a match, `pa_o` = {physical page, `va_i[11:0]`} and `nc_o` = NonCacheable.
- R8: When several entries match a lookup, the lowest-numbered entry supplies the result.
- R9: A lookup with no matching entry gives `fault_o`=3, `pa_o`=0 and `nc_o`=0.
- R10: A match on an entry whose Valid bit is clear gives `fault_o`=5, whatever the access type.
- R11: A store (`store_i`=1) that matches a valid entry whose Dirty bit is clear gives `fault_o`=4. A load to such an entry, and a store to a valid entry with Dirty set, give `fault_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command: 0 idle, 1 indexed read, 2 indexed write, 3 random write, 4 probe |
| stg_we_i | input | 1 | Staging register write strobe |
| stg_sel_i | input | 2 | Staging register select: 0 index, 1 low, 2 high |
| stg_wdata_i | input | 32 | Staging register write data |
| index_o | output | 32 | Index register |
| hi_o | output | 32 | Staging high word |
| lo_o | output | 32 | Staging low word |
| rand_o | output | 6 | Random replacement index |
| va_i | input | 32 | Lookup virtual address |
| asid_i | input | 12 | Current address-space ID |
| store_i | input | 1 | Lookup access is a store |
| pa_o | output | 32 | Translated physical address |
| nc_o | output | 1 | Translated page is non-cacheable |
| fault_o | output | 4 | Fault cause: 0 none, 3 miss, 4 modify, 5 invalid |

## Verification
The hardest case to reach from the ports is a random write landing on a chosen entry. The target is picked by a counter that runs every clock, independently of the stimulus. The bench reads `rand_o` on the falling edge where it drives the command, so it knows the expected target. It skips that edge if the target would overwrite an entry still in use, then checks the result through an indexed read and a lookup. Overlapping matches are built on purpose: a global entry, a duplicate high word at a higher index, and untouched zero entries that probe finds first. These expose the lowest-index priority in both lookup and probe.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned TLB_ENTRIES = 64;
    localparam int unsigned RAND_FLOOR  = 8;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned PAGE_BITS   = 12;
    localparam int unsigned ASID_W      = 12;
    localparam int unsigned VPN_W       = WORD_W - PAGE_BITS;
    localparam int unsigned PPN_W       = WORD_W - PAGE_BITS;
    localparam int unsigned RSVD_W      = PAGE_BITS - 4;

    localparam logic [WORD_W-1:0] PROBE_NONE = 32'h8000_0000;

    typedef enum logic [2:0] {
        CMD_IDLE      = 3'd0,
        CMD_READ      = 3'd1,
        CMD_WRITE_IDX = 3'd2,
        CMD_WRITE_RND = 3'd3,
        CMD_PROBE     = 3'd4
    } tlb_cmd_e;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_LOW   = 2'd1,
        SEL_HIGH  = 2'd2,
        SEL_NONE  = 2'd3
    } stage_sel_e;

    typedef enum logic [3:0] {
        FLT_NONE    = 4'd0,
        FLT_MISS    = 4'd3,
        FLT_MODIFY  = 4'd4,
        FLT_INVALID = 4'd5
    } fault_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
    } ent_hi_t;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [RSVD_W-1:0] rsvd;
        logic              glob;
        logic              dirty;
        logic              nocache;
        logic              valid;
    } ent_lo_t;

    typedef struct packed {
        ent_hi_t hi;
        ent_lo_t lo;
    } tlb_entry_t;

    function automatic logic lookup_hit(input tlb_entry_t e,
                                        input logic [VPN_W-1:0] vpn,
                                        input logic [ASID_W-1:0] asid);
        return (e.hi.vpn == vpn) && (e.lo.glob || (e.hi.asid == asid));
    endfunction

    function automatic fault_e classify(input logic found, input ent_lo_t lo,
                                        input logic is_store);
        if (!found)                 return FLT_MISS;
        if (!lo.valid)              return FLT_INVALID;
        if (is_store && !lo.dirty)  return FLT_MODIFY;
        return FLT_NONE;
    endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int unsigned N  = TLB_ENTRIES,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [IW-1:0]        waddr_i,
    input  tlb_entry_t           wdata_i,
    output tlb_entry_t [N-1:0]   ents_o
);
    tlb_entry_t [N-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign ents_o = mem_q;

    // R3 / R5: a write strobe lands its data at the addressed slot
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (ents_o[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int unsigned N = TLB_ENTRIES
) (
    input  tlb_entry_t [N-1:0]  ents_i,
    input  logic [VPN_W-1:0]    vpn_i,
    input  logic [ASID_W-1:0]   asid_i,
    input  ent_hi_t             key_i,
    output logic [N-1:0]        lk_vec_o,
    output logic [N-1:0]        pr_vec_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lk_vec_o[g] = lookup_hit(ents_i[g], vpn_i, asid_i);
        assign pr_vec_o[g] = (ents_i[g].hi == key_i);
    end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int unsigned N  = 64,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign found_o = |vec_i;

    // R8: the chosen slot is set and nothing below it is set
    always_comb begin
        if (found_o) begin
            p_lowest_wins_r8: assert (vec_i[idx_o] && ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/tlb_rand.sv
module tlb_rand
    import tlb_pkg::*;
#(
    parameter int unsigned N     = TLB_ENTRIES,
    parameter int unsigned FLOOR = RAND_FLOOR,
    localparam int unsigned IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] idx_o
);
    localparam logic [IW-1:0] TOP = IW'(N - 1);
    localparam logic [IW-1:0] BOT = IW'(FLOOR);

    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= TOP;
        else if (cnt_q == BOT) cnt_q <= TOP;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign idx_o = cnt_q;

    p_rand_range_r4: assert property (@(posedge clk) disable iff (rst)
        (idx_o >= BOT) && (idx_o <= TOP));

    p_rand_step_r4: assert property (@(posedge clk) disable iff (rst)
        (idx_o != BOT) |=> (idx_o == $past(idx_o) - 1'b1));

    p_rand_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (idx_o == BOT) |=> (idx_o == TOP));
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    parameter int unsigned FLOOR   = RAND_FLOOR,
    localparam int unsigned IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_i,
    input  logic              stg_we_i,
    input  logic [1:0]        stg_sel_i,
    input  logic [31:0]       stg_wdata_i,
    output logic [31:0]       index_o,
    output logic [31:0]       hi_o,
    output logic [31:0]       lo_o,
    output logic [IW-1:0]     rand_o,
    input  logic [31:0]       va_i,
    input  logic [ASID_W-1:0] asid_i,
    input  logic              store_i,
    output logic [31:0]       pa_o,
    output logic              nc_o,
    output logic [3:0]        fault_o
);
    tlb_cmd_e cmd;
    assign cmd = tlb_cmd_e'(cmd_i);

    logic [31:0]  index_q;
    ent_hi_t      hi_q;
    ent_lo_t      lo_q;
    logic [IW-1:0] rnd_idx;

    tlb_entry_t [ENTRIES-1:0] ents;
    logic [ENTRIES-1:0] lk_vec, pr_vec;
    logic               lk_found, pr_found;
    logic [IW-1:0]      lk_idx, pr_idx;

    // ---- storage and write path ----
    logic          arr_we;
    logic [IW-1:0] arr_addr;

    always_comb begin
        arr_we   = (cmd == CMD_WRITE_IDX) || (cmd == CMD_WRITE_RND);
        arr_addr = (cmd == CMD_WRITE_RND) ? rnd_idx : index_q[IW-1:0];
    end

    tlb_array #(.N(ENTRIES)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we_i    (arr_we),
        .waddr_i (arr_addr),
        .wdata_i ({hi_q, lo_q}),
        .ents_o  (ents)
    );

    tlb_rand #(.N(ENTRIES), .FLOOR(FLOOR)) u_rand (
        .clk   (clk),
        .rst   (rst),
        .idx_o (rnd_idx)
    );

    // ---- associative compare, shared by lookup and probe ----
    tlb_match #(.N(ENTRIES)) u_match (
        .ents_i   (ents),
        .vpn_i    (va_i[31:PAGE_BITS]),
        .asid_i   (asid_i),
        .key_i    (hi_q),
        .lk_vec_o (lk_vec),
        .pr_vec_o (pr_vec)
    );

    tlb_first #(.N(ENTRIES)) u_first_lk (
        .vec_i   (lk_vec),
        .found_o (lk_found),
        .idx_o   (lk_idx)
    );

    tlb_first #(.N(ENTRIES)) u_first_pr (
        .vec_i   (pr_vec),
        .found_o (pr_found),
        .idx_o   (pr_idx)
    );

    // ---- staging registers; a command overrides a register write ----
    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            if (stg_we_i) begin
                case (stage_sel_e'(stg_sel_i))
                    SEL_INDEX: index_q <= stg_wdata_i;
                    SEL_LOW:   lo_q    <= stg_wdata_i;
                    SEL_HIGH:  hi_q    <= stg_wdata_i;
                    default: ;
                endcase
            end
            case (cmd)
                CMD_READ: begin
                    hi_q <= ents[index_q[IW-1:0]].hi;
                    lo_q <= ents[index_q[IW-1:0]].lo;
                end
                CMD_PROBE: index_q <= pr_found ? 32'(pr_idx) : PROBE_NONE;
                default: ;
            endcase
        end
    end

    assign index_o = index_q;
    assign hi_o    = hi_q;
    assign lo_o    = lo_q;
    assign rand_o  = rnd_idx;

    // ---- lookup result ----
    tlb_entry_t sel_ent;
    fault_e     flt;

    always_comb begin
        sel_ent = lk_found ? ents[lk_idx] : '0;
        flt     = classify(lk_found, sel_ent.lo, store_i);
        pa_o    = lk_found ? {sel_ent.lo.ppn, va_i[PAGE_BITS-1:0]} : '0;
        nc_o    = lk_found && sel_ent.lo.nocache;
        fault_o = flt;
    end

    // ---- assertions ----
    p_probe_code_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PROBE) |=> ((index_o == PROBE_NONE) || (index_o < 32'(ENTRIES))));

    p_read_copies_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_READ) |=> ({hi_o, lo_o} == $past(ents[index_q[IW-1:0]])));

    p_miss_nohit_r9: assert property (@(posedge clk) disable iff (rst)
        ((fault_o == 4'(FLT_MISS)) == (lk_vec == '0)));

    p_modify_store_r11: assert property (@(posedge clk) disable iff (rst)
        (fault_o == 4'(FLT_MODIFY)) |-> store_i);

    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_o == 4'(FLT_MISS)) |-> ((pa_o == '0) && !nc_o));
endmodule

// File: tb/test_soft_tlb.sv
`timescale 1ns/1ps
module test_soft_tlb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_i = '0;
    logic        stg_we_i = 1'b0;
    logic [1:0]  stg_sel_i = '0;
    logic [31:0] stg_wdata_i = '0;
    logic [31:0] index_o, hi_o, lo_o, pa_o;
    logic [5:0]  rand_o;
    logic [31:0] va_i = '0;
    logic [11:0] asid_i = '0;
    logic        store_i = 1'b0;
    logic        nc_o;
    logic [3:0]  fault_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    soft_tlb i_soft_tlb (
        .clk(clk), .rst(rst), .cmd_i(cmd_i),
        .stg_we_i(stg_we_i), .stg_sel_i(stg_sel_i), .stg_wdata_i(stg_wdata_i),
        .index_o(index_o), .hi_o(hi_o), .lo_o(lo_o), .rand_o(rand_o),
        .va_i(va_i), .asid_i(asid_i), .store_i(store_i),
        .pa_o(pa_o), .nc_o(nc_o), .fault_o(fault_o)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [11:0] asid;
        logic        st;
        logic [31:0] pa;
        logic        nc;
        logic [3:0]  flt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0ABC, 12'h005, 1'b0, 32'hAAAA_AABC, 1'b0, 4'd0}, // R7 R8
        '{32'h0001_0ABC, 12'h005, 1'b1, 32'hAAAA_AABC, 1'b0, 4'd0}, // R11 dirty store
        '{32'h0001_0ABC, 12'h006, 1'b0, 32'h0000_0000, 1'b0, 4'd3}, // R9 asid differs
        '{32'h0002_0123, 12'h3FF, 1'b0, 32'hBBBB_B123, 1'b1, 4'd0}, // R7 global
        '{32'h0002_0123, 12'h007, 1'b1, 32'hBBBB_B123, 1'b1, 4'd4}, // R11 modify
        '{32'h0003_0FFF, 12'h005, 1'b0, 32'hCCCC_CFFF, 1'b0, 4'd5}, // R10 load
        '{32'h0003_0FFF, 12'h005, 1'b1, 32'hCCCC_CFFF, 1'b0, 4'd5}, // R10 store
        '{32'h0004_0000, 12'h009, 1'b1, 32'h1234_5000, 1'b1, 4'd0}, // R7
        '{32'h0005_0000, 12'h009, 1'b0, 32'h0000_0000, 1'b0, 4'd3}  // R9
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        stg_we_i = 1'b1; stg_sel_i = sel; stg_wdata_i = d;
        @(negedge clk);
        stg_we_i = 1'b0;
    endtask

    task automatic do_cmd(input logic [2:0] c);
        @(negedge clk);
        cmd_i = c;
        @(negedge clk);
        cmd_i = 3'd0;
    endtask

    task automatic put_entry(input logic [31:0] idx, input logic [31:0] hi, input logic [31:0] lo);
        wr_reg(2'd0, idx);
        wr_reg(2'd2, hi);
        wr_reg(2'd1, lo);
        do_cmd(3'd2);
    endtask

    task automatic look(input logic [31:0] va, input logic [11:0] asid, input logic st);
        @(negedge clk);
        va_i = va; asid_i = asid; store_i = st;
        #1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        chk("R1 index", index_o, 32'h0);
        chk("R1 high", hi_o, 32'h0);
        chk("R1 low", lo_o, 32'h0);
        chk("R1 rand", 32'(rand_o), 32'd63);
        look(32'h0001_0ABC, 12'h005, 1'b0);
        chk("R1 empty miss", 32'(fault_o), 32'd3);

        // R4 counter sequence over more than one wrap
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            r = rand_o;
            @(negedge clk);
            chk("R4 step", 32'(rand_o), (r == 6'd8) ? 32'd63 : 32'(r) - 32'd1);
        end

        // R2 staging writes, select 3 writes nothing
        wr_reg(2'd2, 32'hDEAD_BEEF);
        chk("R2 high", hi_o, 32'hDEAD_BEEF);
        wr_reg(2'd3, 32'h1111_1111);
        chk("R2 sel3 high", hi_o, 32'hDEAD_BEEF);
        chk("R2 sel3 low", lo_o, 32'h0);
        chk("R2 sel3 index", index_o, 32'h0);

        // R3 load entries by indexed write
        put_entry(32'd0, 32'h0001_0005, 32'hAAAA_A005);
        put_entry(32'd1, 32'h0002_0007, 32'hBBBB_B00B);
        put_entry(32'd2, 32'h0003_0005, 32'hCCCC_C004);
        put_entry(32'd5, 32'h0001_0005, 32'hDDDD_D005);
        put_entry(32'd9, 32'h0004_0009, 32'h1234_5007);

        // R7..R11 table of lookups
        for (int v = 0; v < NV; v++) begin
            look(VECS[v].va, VECS[v].asid, VECS[v].st);
            chk("R7 pa", pa_o, VECS[v].pa);
            chk("R7 nc", 32'(nc_o), 32'(VECS[v].nc));
            chk("R9 R10 R11 fault", 32'(fault_o), 32'(VECS[v].flt));
        end

        // R3 indexed read
        wr_reg(2'd0, 32'd9);
        do_cmd(3'd1);
        chk("R3 read high", hi_o, 32'h0004_0009);
        chk("R3 read low", lo_o, 32'h1234_5007);

        // R6 probe: duplicate picks lowest, zero word finds first empty slot
        wr_reg(2'd2, 32'h0001_0005);
        do_cmd(3'd4);
        chk("R6 probe dup", index_o, 32'd0);
        wr_reg(2'd2, 32'h0004_0009);
        do_cmd(3'd4);
        chk("R6 probe hit", index_o, 32'd9);
        wr_reg(2'd2, 32'h0000_0000);
        do_cmd(3'd4);
        chk("R6 probe empty", index_o, 32'd3);
        wr_reg(2'd2, 32'h0BAD_0001);
        do_cmd(3'd4);
        chk("R6 probe miss", index_o, 32'h8000_0000);

        // R5 random write, avoiding entry 9
        wr_reg(2'd2, 32'h0006_0001);
        wr_reg(2'd1, 32'h7777_7003);
        @(negedge clk);
        while (rand_o == 6'd9) @(negedge clk);
        r = rand_o;
        cmd_i = 3'd3;
        @(negedge clk);
        cmd_i = 3'd0;
        look(32'h0006_0010, 12'h001, 1'b0);
        chk("R5 lookup pa", pa_o, 32'h7777_7010);
        chk("R5 lookup nc", 32'(nc_o), 32'd1);
        look(32'h0006_0010, 12'h001, 1'b1);
        chk("R5 store modify", 32'(fault_o), 32'd4);
        wr_reg(2'd2, 32'h0006_0001);
        do_cmd(3'd4);
        chk("R5 slot", index_o, 32'(r));
        chk("R5 slot floor", 32'(index_o >= 32'd8), 32'd1);

        // R1 reset after use clears entries
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        look(32'h0001_0ABC, 12'h005, 1'b0);
        chk("R1 re-reset miss", 32'(fault_o), 32'd3);
        chk("R1 re-reset index", index_o, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule